// File: doc/BRIEF.md
# PCI Target Termination Controller

This block is the target-side control path of a simplified PCI slave port. It watches the shared bus for address phases. It claims memory reads and memory writes that fall inside its base window, and it drives the target response lines DEVSEL#, TRDY# and STOP# through an output enable. Each claimed access ends in one of three ways: a normal completion, a disconnect once a burst grows too long, or a target abort.

The claimed window has two halves. The lower half holds a small internal register space. The upper half bridges to a local bus through a request/acknowledge handshake. The local bus carries only some byte-lane combinations. A data phase aimed at the bridged half with any other combination is refused with a target abort, and the abort sets a sticky status flag. Software clears that flag by writing a one to it. The controller accepts a new address phase in the clock right after any final data phase, whether that data phase belonged to this target or to another agent on the bus.

Top module: `pci_tgt_term`

## Requirements
- R1: An address phase is a rising clock edge at which FRAME# is low and FRAME# was high at the previous edge. When C/BE# is 0110 (memory read) or 0111 (memory write) and AD[31:12] equals the base window, the block claims the access. The output enable is on after that edge. DEVSEL# first goes low after the next edge.
- R2: In the internal half (AD[11]=0), TRDY# goes low for one clock after the first edge at which IRDY# is sampled low. In the bridged half (AD[11]=1), lb_req is high while IRDY# is low, and TRDY# goes low for one clock after the edge that samples lb_ack high. For a burst, lb_addr holds the window offset bits [10:0] of the current beat.
- R3: The bridged half accepts the byte-enable patterns 0000, 0011, 1100, 1110, 1101, 1011 and 0111 (C/BE#, active low). Every other pattern, 1111 included, is unsupported.
- R4: A data phase in the bridged half with an unsupported pattern produces a target abort. STOP# goes low while DEVSEL# is high. TRDY# never goes low and lb_req is never raised for that access.
- R5: Every target abort sets sts_tabort, and the flag stays set across later transactions.
- R6: A completed memory write to internal offset 0x004 clears sts_tabort when AD[27] is 1 and C/BE#[3] is 0. If AD[27] is 0, if byte lane 3 is disabled, or if the write goes to any other offset, the flag is left unchanged.
- R7: After MAX_BURST (default 4) completed data phases, the next data phase is a disconnect. STOP# and DEVSEL# are low and TRDY# is high.
- R8: STOP# stays low until an edge samples FRAME# high. After that edge, DEVSEL#, TRDY# and STOP# are driven high for one clock before the output enable drops.
- R9: An edge that samples FRAME# high together with IRDY# and TRDY# low is the final data phase. One turnaround clock follows, with all three signals driven high, and then the block returns to idle.
- R10: If a new address phase for this target arrives in the clock right after this target's final data phase, it is claimed with the same DEVSEL# timing as in R1.
- R11: If a new address phase for this target arrives in the clock right after another agent's final data phase, it is claimed. Data phases of the other agent's transaction are never taken as addresses, even when the AD and C/BE# values on the bus would match this target.
- R12: Other commands, addresses outside the window, and a bus left idle all leave the output enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_n_i | input | 1 | FRAME#, active low |
| irdy_n_i | input | 1 | IRDY#, active low |
| ad_i | input | 32 | Address/data bus as seen by the target |
| cbe_n_i | input | 4 | Command in the address phase, byte enables in data phases |
| devsel_n_o | output | 1 | DEVSEL#, active low |
| trdy_n_o | output | 1 | TRDY#, active low |
| stop_n_o | output | 1 | STOP#, active low |
| tgt_oe_o | output | 1 | Output enable for DEVSEL#, TRDY# and STOP# |
| lb_req_o | output | 1 | Local-bus transfer request |
| lb_we_o | output | 1 | Local-bus write when high |
| lb_addr_o | output | 11 | Local-bus byte address of the current beat |
| lb_be_n_o | output | 4 | Local-bus byte enables, active low |
| lb_wdata_o | output | 32 | Local-bus write data |
| lb_ack_i | input | 1 | Local-bus acknowledge |
| sts_tabort_o | output | 1 | Sticky flag: a target abort was issued |

## Verification
The hardest case to reach from the ports is the type-2 fast back-to-back case. Here another agent runs a burst whose data phases put this target's own base address and a memory-read code on AD and C/BE#. That agent ends with a final data phase, and in the very next clock the bench drives a genuine address for this target. The bench checks that nothing is claimed during the foreign burst and that the following address is claimed on time. A second hard case is holding FRAME# low for extra clocks after STOP# appears, during both an abort and a disconnect, so that the hold-then-turnaround sequence is observed. The bench also sweeps all sixteen byte-enable patterns against the bridged half.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DEC,
    S_DATA,
    S_XFER,
    S_DISC,
    S_ABORT,
    S_TURN
  } tgt_state_e;

  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;

  // Byte-lane patterns (active low) the bridged local bus can carry.
  function automatic logic lb_be_ok(input logic [3:0] be_n);
    logic ok;
    case (be_n)
      4'b0000, 4'b0011, 4'b1100,
      4'b1110, 4'b1101, 4'b1011, 4'b0111: ok = 1'b1;
      default:                            ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/pci_bus_mon.sv
module pci_bus_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_n_i,
  output logic addr_phase_o
);

  logic frame_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_prev_q <= 1'b1;
    else        frame_prev_q <= frame_n_i;
  end

  // FRAME# falling as seen at this edge marks an address phase; this also
  // holds right after a final data phase of any agent.
  assign addr_phase_o = !frame_n_i && frame_prev_q;

endmodule

// File: rtl/pci_tgt_decode.sv
module pci_tgt_decode
  import pci_tgt_pkg::*;
#(
  parameter logic [31:0] BAR_BASE   = 32'h8000_0000,
  parameter int          BAR_BITS   = 12,
  parameter int          LB_SEL_BIT = 11
) (
  input  logic [31:0]         ad_i,
  input  logic [3:0]          cbe_n_i,
  output logic                hit_o,
  output logic                lb_win_o,
  output logic                is_wr_o,
  output logic [BAR_BITS-1:0] off_o
);

  logic base_match;
  logic mem_cmd;

  always_comb begin
    base_match = (ad_i[31:BAR_BITS] == BAR_BASE[31:BAR_BITS]);
    mem_cmd    = (cbe_n_i == CMD_MEM_RD) || (cbe_n_i == CMD_MEM_WR);
    hit_o      = base_match && mem_cmd;
    lb_win_o   = ad_i[LB_SEL_BIT];
    is_wr_o    = (cbe_n_i == CMD_MEM_WR);
    off_o      = ad_i[BAR_BITS-1:0];
  end

endmodule

// File: rtl/pci_tgt_sts.sv
module pci_tgt_sts (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_d;
  logic flag_q;

  always_comb begin
    flag_d = flag_q;
    if (clr_i) flag_d = 1'b0;
    if (set_i) flag_d = 1'b1;   // a new abort wins over a clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/pci_tgt_term.sv
module pci_tgt_term
  import pci_tgt_pkg::*;
#(
  parameter logic [31:0] BAR_BASE   = 32'h8000_0000,
  parameter int          BAR_BITS   = 12,
  parameter int          LB_SEL_BIT = 11,
  parameter int          LB_AW      = 11,
  parameter int          MAX_BURST  = 4,
  parameter int          STS_BIT    = 27,
  parameter int unsigned STS_OFF    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_n_i,
  input  logic             irdy_n_i,
  input  logic [31:0]      ad_i,
  input  logic [3:0]       cbe_n_i,
  output logic             devsel_n_o,
  output logic             trdy_n_o,
  output logic             stop_n_o,
  output logic             tgt_oe_o,
  output logic             lb_req_o,
  output logic             lb_we_o,
  output logic [LB_AW-1:0] lb_addr_o,
  output logic [3:0]       lb_be_n_o,
  output logic [31:0]      lb_wdata_o,
  input  logic             lb_ack_i,
  output logic             sts_tabort_o
);

  localparam int                  BEAT_W    = $clog2(MAX_BURST + 1);
  localparam int                  STS_LANE  = STS_BIT / 8;
  localparam logic [BAR_BITS-1:0] STS_OFF_L = BAR_BITS'(STS_OFF);
  localparam logic [BEAT_W-1:0]   BEAT_MAX  = BEAT_W'(MAX_BURST);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  // bus phase tracking and address decode
  logic                addr_phase;
  logic                dec_hit;
  logic                dec_lb;
  logic                dec_wr;
  logic [BAR_BITS-1:0] dec_off;

  pci_bus_mon u_mon (
    .clk          (clk),
    .rst_n        (rst_q_n),
    .frame_n_i    (frame_n_i),
    .addr_phase_o (addr_phase)
  );

  pci_tgt_decode #(
    .BAR_BASE   (BAR_BASE),
    .BAR_BITS   (BAR_BITS),
    .LB_SEL_BIT (LB_SEL_BIT)
  ) u_dec (
    .ad_i     (ad_i),
    .cbe_n_i  (cbe_n_i),
    .hit_o    (dec_hit),
    .lb_win_o (dec_lb),
    .is_wr_o  (dec_wr),
    .off_o    (dec_off)
  );

  // state and transaction context
  tgt_state_e          state_q, state_d;
  logic                lb_q, wr_q;
  logic [BAR_BITS-1:0] off_q;
  logic [BEAT_W-1:0]   beats_q, beats_d;
  logic                ctx_en, beats_en;

  logic                claim;
  logic                at_limit;
  logic                be_ok;
  logic                dphase;
  logic                abort_req;
  logic                disc_req;
  logic                go_xfer;
  logic                xfer_done;
  logic                sts_clr;
  logic [BAR_BITS-1:0] cur_off;

  always_comb begin
    claim     = addr_phase && dec_hit && (state_q == S_IDLE || state_q == S_TURN);
    at_limit  = (beats_q == BEAT_MAX);
    be_ok     = lb_be_ok(cbe_n_i);
    dphase    = (state_q == S_DATA) && !irdy_n_i;
    abort_req = dphase && lb_q && !be_ok;               // abort outranks disconnect
    disc_req  = dphase && !abort_req && at_limit;
    go_xfer   = dphase && !abort_req && !at_limit && (!lb_q || lb_ack_i);
    xfer_done = (state_q == S_XFER) && !irdy_n_i;
    cur_off   = off_q + BAR_BITS'({beats_q, 2'b00});
    sts_clr   = xfer_done && wr_q && !lb_q && (cur_off == STS_OFF_L)
                && ad_i[STS_BIT] && !cbe_n_i[STS_LANE];
  end

  // next state
  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE:  if (claim) state_d = S_DEC;
      S_DEC:   state_d = S_DATA;
      S_DATA: begin
        if (abort_req)     state_d = S_ABORT;
        else if (disc_req) state_d = S_DISC;
        else if (go_xfer)  state_d = S_XFER;
      end
      S_XFER:  if (xfer_done) state_d = frame_n_i ? S_TURN : S_DATA;
      S_DISC,
      S_ABORT: if (frame_n_i) state_d = S_TURN;
      S_TURN:  state_d = claim ? S_DEC : S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_comb begin
    ctx_en   = claim;
    beats_en = claim || xfer_done;
    beats_d  = claim ? '0 : beats_q + BEAT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) state_q <= S_IDLE;
    else          state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      lb_q  <= 1'b0;
      wr_q  <= 1'b0;
      off_q <= '0;
    end else if (ctx_en) begin
      lb_q  <= dec_lb;
      wr_q  <= dec_wr;
      off_q <= dec_off;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)      beats_q <= '0;
    else if (beats_en) beats_q <= beats_d;
  end

  pci_tgt_sts u_sts (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .set_i  (abort_req),
    .clr_i  (sts_clr),
    .flag_o (sts_tabort_o)
  );

  // bus responses decoded from the state register
  always_comb begin
    devsel_n_o = !(state_q == S_DATA || state_q == S_XFER || state_q == S_DISC);
    trdy_n_o   = !(state_q == S_XFER);
    stop_n_o   = !(state_q == S_DISC || state_q == S_ABORT);
    tgt_oe_o   = (state_q != S_IDLE);
  end

  // local-bus side
  always_comb begin
    lb_req_o   = dphase && lb_q && be_ok && !at_limit;
    lb_we_o    = wr_q;
    lb_addr_o  = cur_off[LB_AW-1:0];
    lb_be_n_o  = cbe_n_i;
    lb_wdata_o = ad_i;
  end

  // assertions
  assert_devsel_medium_R1: assert property (@(posedge clk) disable iff (!rst_q_n)
    $fell(devsel_n_o) |-> $past(claim, 2));

  assert_abort_no_data_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!stop_n_o && devsel_n_o) |-> (trdy_n_o && !lb_req_o));

  assert_abort_cause_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(state_q == S_ABORT) |-> $past(lb_q && !lb_be_ok(cbe_n_i) && !irdy_n_i));

  assert_abort_sticky_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(!stop_n_o && devsel_n_o) |-> sts_tabort_o);

  assert_stop_hold_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!stop_n_o && !frame_n_i) |=> !stop_n_o);

  assert_turnaround_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    $fell(tgt_oe_o) |-> $past(devsel_n_o && trdy_n_o && stop_n_o));

  assert_xfer_one_clk_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!trdy_n_o && !irdy_n_i) |=> trdy_n_o);

endmodule

// File: tb/pci_tgt_term_tb.sv
`timescale 1ns/100ps
module pci_tgt_term_tb;

  localparam logic [31:0] BASE  = 32'h8000_0000;
  localparam logic [3:0]  RD    = 4'b0110;
  localparam logic [3:0]  WR    = 4'b0111;
  localparam int          MAXB  = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_n, irdy_n, lb_ack;
  logic [31:0] ad;
  logic [3:0]  cbe_n;
  logic        devsel_n, trdy_n, stop_n, oe, lb_req, lb_we, sts;
  logic [10:0] lb_addr;
  logic [3:0]  lb_be_n;
  logic [31:0] lb_wdata;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pci_tgt_term u_dut (
    .clk (clk), .rst_n (rst_n),
    .frame_n_i (frame_n), .irdy_n_i (irdy_n), .ad_i (ad), .cbe_n_i (cbe_n),
    .devsel_n_o (devsel_n), .trdy_n_o (trdy_n), .stop_n_o (stop_n), .tgt_oe_o (oe),
    .lb_req_o (lb_req), .lb_we_o (lb_we), .lb_addr_o (lb_addr), .lb_be_n_o (lb_be_n),
    .lb_wdata_o (lb_wdata), .lb_ack_i (lb_ack), .sts_tabort_o (sts)
  );

  function automatic bit exp_be_ok(input logic [3:0] be);
    return be inside {4'b0000, 4'b0011, 4'b1100, 4'b1110, 4'b1101, 4'b1011, 4'b0111};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drv(input logic f, input logic i, input logic [3:0] be, input logic [31:0] a);
    frame_n = f; irdy_n = i; cbe_n = be; ad = a;
  endtask

  task automatic nxt;
    @(negedge clk);
  endtask

  task automatic chk_turn(input string req);
    chk(req, "oe in turnaround", oe, 1);
    chk(req, "devsel# in turnaround", devsel_n, 1);
    chk(req, "trdy# in turnaround", trdy_n, 1);
    chk(req, "stop# in turnaround", stop_n, 1);
  endtask

  task automatic t_reset;
    chk("R12", "oe after reset", oe, 0);
    chk("R12", "devsel# after reset", devsel_n, 1);
    chk("R12", "stop# after reset", stop_n, 1);
    chk("R5", "status after reset", sts, 0);
    chk("R2", "lb_req after reset", lb_req, 0);
  endtask

  // single-beat access to the internal half
  task automatic int_single(input logic [31:0] a, input logic [3:0] cmd,
                            input logic [3:0] be, input logic [31:0] d, input string req);
    drv(0, 1, cmd, a); nxt;
    chk("R1", "oe after address", oe, 1);
    chk("R1", "devsel# one clock after address", devsel_n, 1);
    drv(1, 0, be, d); nxt;
    chk("R1", "devsel# two clocks after address", devsel_n, 0);
    chk(req, "trdy# before data", trdy_n, 1);
    nxt;
    chk("R2", "trdy# internal data", trdy_n, 0);
    nxt;
    chk_turn("R9");
    drv(1, 1, 4'hF, 0); nxt;
    chk("R9", "oe released", oe, 0);
  endtask

  // single-beat access to the bridged half, with local-bus wait clocks
  task automatic lb_single(input logic [3:0] be, input int waits, input string req);
    bit ok;
    ok = exp_be_ok(be);
    drv(0, 1, RD, BASE | 32'h804); nxt;
    chk("R1", "devsel# one clock after address", devsel_n, 1);
    drv(1, 0, be, 0); nxt;
    chk(req, "devsel# in data", devsel_n, 0);
    chk(req, "lb_req vs byte enables", lb_req, ok);
    if (ok) begin
      chk("R2", "lb_addr", lb_addr, 11'h004);
      chk("R2", "lb_be_n", lb_be_n, be);
      for (int w = 0; w < waits; w++) begin
        nxt;
        chk("R2", "trdy# while waiting", trdy_n, 1);
        chk("R2", "lb_req held", lb_req, 1);
      end
      lb_ack = 1'b1; nxt; lb_ack = 1'b0;
      chk("R2", "trdy# after ack", trdy_n, 0);
      chk(req, "stop# on supported pattern", stop_n, 1);
    end else begin
      nxt;
      chk("R4", "stop# on abort", stop_n, 0);
      chk("R4", "devsel# on abort", devsel_n, 1);
      chk("R4", "trdy# on abort", trdy_n, 1);
      chk("R5", "status set by abort", sts, 1);
    end
    nxt;
    chk_turn("R8");
    drv(1, 1, 4'hF, 0); nxt;
    chk("R8", "oe released", oe, 0);
  endtask

  task automatic t_be_sweep;
    for (int b = 0; b < 16; b++) lb_single(4'(b), 0, "R3");
  endtask

  task automatic t_abort_burst;
    drv(0, 1, RD, BASE | 32'h800); nxt;
    drv(0, 0, 4'b1010, 0); nxt;
    chk("R4", "no lb_req for bad pattern", lb_req, 0);
    nxt;
    chk("R4", "stop# burst abort", stop_n, 0);
    chk("R4", "devsel# burst abort", devsel_n, 1);
    chk("R5", "status set", sts, 1);
    nxt;
    chk("R8", "stop# held while FRAME# low", stop_n, 0);
    chk("R4", "trdy# still high", trdy_n, 1);
    drv(1, 0, 4'b1010, 0); nxt;
    chk_turn("R8");
    drv(1, 1, 4'hF, 0); nxt;
    chk("R8", "oe released after abort", oe, 0);
  endtask

  task automatic t_w1c;
    int_single(BASE | 32'h004, WR, 4'b0000, 32'h0, "R6");
    chk("R6", "write of 0 keeps flag", sts, 1);
    int_single(BASE | 32'h004, WR, 4'b1000, 32'h0800_0000, "R6");
    chk("R6", "lane 3 disabled keeps flag", sts, 1);
    int_single(BASE | 32'h008, WR, 4'b0000, 32'h0800_0000, "R6");
    chk("R6", "other offset keeps flag", sts, 1);
    int_single(BASE | 32'h004, WR, 4'b0000, 32'h0800_0000, "R6");
    chk("R6", "write one clears flag", sts, 0);
  endtask

  task automatic t_disconnect;
    int beats = 0;
    drv(0, 1, RD, BASE | 32'h010); nxt;
    drv(0, 0, 4'b0000, 0);
    for (int k = 0; k < 20; k++) begin
      nxt;
      if (trdy_n == 1'b0) beats++;
      if (stop_n == 1'b0) break;
    end
    chk("R7", "beats before disconnect", beats, MAXB);
    chk("R7", "stop# on disconnect", stop_n, 0);
    chk("R7", "devsel# on disconnect", devsel_n, 0);
    chk("R7", "trdy# on disconnect", trdy_n, 1);
    nxt;
    chk("R8", "stop# held in disconnect", stop_n, 0);
    drv(1, 0, 4'b0000, 0); nxt;
    chk_turn("R8");
    drv(1, 1, 4'hF, 0); nxt;
    chk("R7", "oe released after disconnect", oe, 0);
    chk("R5", "disconnect leaves flag", sts, 0);
  endtask

  task automatic t_b2b_same;
    drv(0, 1, RD, BASE | 32'h000); nxt;
    drv(1, 0, 4'b0000, 0); nxt;
    nxt;
    chk("R10", "first trdy#", trdy_n, 0);
    nxt;
    chk_turn("R10");
    drv(0, 1, RD, BASE | 32'h008); nxt;
    chk("R10", "oe kept for new address", oe, 1);
    chk("R10", "devsel# one clock after", devsel_n, 1);
    drv(1, 0, 4'b0000, 0); nxt;
    chk("R10", "devsel# claims second", devsel_n, 0);
    nxt;
    chk("R10", "second trdy#", trdy_n, 0);
    nxt;
    chk_turn("R9");
    drv(1, 1, 4'hF, 0); nxt;
    chk("R10", "oe released", oe, 0);
  endtask

  task automatic t_b2b_other;
    drv(0, 1, RD, 32'h1000_0000); nxt;
    chk("R11", "foreign address not claimed", oe, 0);
    drv(0, 0, RD, BASE | 32'h004); nxt;
    chk("R11", "foreign data phase 1", oe, 0);
    nxt;
    chk("R11", "foreign data phase 2", oe, 0);
    drv(1, 0, RD, BASE | 32'h004); nxt;
    chk("R11", "foreign final phase", oe, 0);
    drv(0, 1, RD, BASE | 32'h000); nxt;
    chk("R11", "oe after own address", oe, 1);
    drv(1, 0, 4'b0000, 0); nxt;
    chk("R11", "devsel# claims", devsel_n, 0);
    nxt;
    chk("R11", "trdy#", trdy_n, 0);
    nxt;
    chk_turn("R9");
    drv(1, 1, 4'hF, 0); nxt;
    chk("R11", "oe released", oe, 0);
  endtask

  task automatic t_ignore;
    drv(0, 1, 4'b1010, BASE); nxt;
    drv(1, 0, 4'b0000, 0);
    for (int k = 0; k < 3; k++) begin
      nxt;
      chk("R12", "other command ignored", oe, 0);
    end
    drv(1, 1, 4'hF, 0); nxt;
    drv(0, 1, RD, 32'h8000_1000); nxt;
    drv(1, 0, 4'b0000, 0);
    for (int k = 0; k < 3; k++) begin
      nxt;
      chk("R12", "outside window ignored", oe, 0);
    end
    drv(1, 1, 4'hF, 0); nxt;
  endtask

  initial begin
    rst_n = 1'b0; lb_ack = 1'b0;
    drv(1, 1, 4'hF, 0);
    repeat (3) nxt;
    rst_n = 1'b1;
    repeat (4) nxt;
    t_reset();
    int_single(BASE | 32'h000, RD, 4'b0000, 0, "R2");
    lb_single(4'b1100, 3, "R2");
    t_be_sweep();
    t_w1c();
    t_abort_burst();
    int_single(BASE | 32'h004, WR, 4'b0000, 32'h0800_0000, "R6");
    chk("R6", "flag cleared again", sts, 0);
    t_disconnect();
    t_b2b_same();
    t_b2b_other();
    t_ignore();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

endmodule